// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital core of an 8-bit successive-approximation analog-to-digital converter. A processor reaches it through three active-low strobes: a select, a start and an output enable. The block steps a trial code through a DAC and comparator that sit outside it. Each bit is settled from the most significant bit down. When the last bit is settled, the block copies the code into a result register and pulls an active-low completion flag low.

Holding select and start low together keeps the sequencer in reset. Raising either one begins a new conversion a few clocks later. A start that arrives during a conversion throws away the partial result and leaves the last finished code in place. A separate mode loops the completion flag back to the start pin, so the block converts continuously without a processor. A pulse on the start pin is needed once after power-up to begin that loop.

Top module: `sar_adc_seq`

## Requirements
- R1: After `rstN` is released, `intrN` is 1, `trialCode` is 0, and with `csN`=`rdN`=1 both `dataOe` and `dataOut` are 0.
- R2: While `csN` and `wrN` are both low (seen through the two-stage synchronizer), `trialCode` is forced to 0 and `intrN` to 1, and no conversion proceeds however long the condition lasts.
- R3: After `csN` or `wrN` rises to end the hold, the first trial code 0x80 appears on `trialCode` between 3 and 8 clocks later. The window comes from 2 synchronizer clocks plus alignment to a free-running divide-by-6 phase.
- R4: Bits are tried from bit 7 down to bit 0. Each trial sets the bit under test and holds it for 8 clocks. The bit is kept only when `cmpHigh`=1, meaning the input is at or above the trial level. A constant input value therefore converts to exactly that value, and the second trial reads 0x40 with bit 7 kept only for inputs of 0x80 or more.
- R5: `intrN` falls between 66 and 73 clocks after the start strobe rises, and at the same edge the final code is loaded into the result register.
- R6: `dataOe` is 1 exactly while `csN`=0 and `rdN`=0, without going through the synchronizer. At those times `dataOut` shows the result register; otherwise `dataOut` is 0. The synchronized start of a read returns `intrN` to 1.
- R7: A hold that begins during a conversion abandons it. The result register keeps the last completed code, and `intrN` stays 1 until a later conversion completes and loads its own code.
- R8: With `csN`=`rdN`=0 and `wrN` driven from `intrN`, the block does nothing until `wrN` is pulsed low once. After that it converts repeatedly. A read held low continuously does not clear `intrN`, because only the start of a read does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low select, asynchronous |
| wrN | input | 1 | Active-low start strobe, asynchronous |
| rdN | input | 1 | Active-low output enable, asynchronous |
| cmpHigh | input | 1 | Comparator decision: input at or above the trial level |
| trialCode | output | 8 | Trial code driven to the external DAC |
| dataOut | output | 8 | Result value, 0 when not enabled |
| dataOe | output | 1 | Data driver enable (stands in for a high-impedance bus) |
| intrN | output | 1 | Active-low conversion-complete flag |

## Verification
The bench steps a table of input levels through full conversions. The table holds 0x00 and 0xFF to cover the all-dropped and all-kept bit patterns, 0x80 and 0x7F on either side of the first decision, the alternating 0x55 and 0xAA, and 0x01 and 0xFE where only the last bit differs from its neighbour. For each level it checks the start latency, the completion time, the second trial code and the value read back. Directed runs then try a long hold, an abort partway through a conversion with a read during the hold, and the free-running loop. The free-running loop is checked both before and after its kick, with the input level changed between conversions.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

  // Strobes from the sequencer to the datapath, at most one active per cycle.
  typedef struct packed {
    logic clrAll;   // clear trial register and bit pointer
    logic loadMsb;  // begin: set the first trial bit
    logic decide;   // settle the bit under test, move to the next
    logic capture;  // copy the settled code into the result register
  } sarStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ALIGN,
    ST_CONV,
    ST_LATCH
  } seqState_t;

endpackage

// File: rtl/sar_adc_sync.sv
module sar_adc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '1;
        else       stageQ <= asyncIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '1;
        else       stageQ <= {stageQ[STAGES-2:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int BIT_CLKS  = 8,
  parameter int PHASE_DIV = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csSync,
  input  logic       wrSync,
  input  logic       rdSync,
  input  logic       lastBit,
  output sarStrobe_t strb,
  output logic       holdActive,
  output logic       intrN
);

  localparam int PHASE_W = (PHASE_DIV > 1) ? $clog2(PHASE_DIV) : 1;
  localparam int CNT_W   = (BIT_CLKS  > 1) ? $clog2(BIT_CLKS)  : 1;
  localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(PHASE_DIV - 1);
  localparam logic [CNT_W-1:0]   CNT_LAST   = CNT_W'(BIT_CLKS - 1);

  seqState_t          stateQ, stateD;
  logic [PHASE_W-1:0] phaseQ;
  logic [CNT_W-1:0]   bitCntQ;
  logic               readPrevQ;
  logic               readNow, readRise, phaseWrap, bitEnd;

  assign holdActive = !csSync && !wrSync;
  assign readNow    = !csSync && !rdSync;
  assign readRise   = readNow && !readPrevQ;
  assign phaseWrap  = (phaseQ == PHASE_LAST);
  assign bitEnd     = (bitCntQ == CNT_LAST);

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    if (holdActive) begin
      strb.clrAll = 1'b1;
      stateD      = ST_HOLD;
    end else begin
      unique case (stateQ)
        ST_IDLE: stateD = ST_IDLE;
        ST_HOLD, ST_ALIGN: begin
          if (phaseWrap) begin
            strb.loadMsb = 1'b1;
            stateD       = ST_CONV;
          end else begin
            stateD = ST_ALIGN;
          end
        end
        ST_CONV: begin
          if (bitEnd) begin
            strb.decide = 1'b1;
            if (lastBit) stateD = ST_LATCH;
          end
        end
        ST_LATCH: begin
          strb.capture = 1'b1;
          stateD       = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      phaseQ    <= '0;
      bitCntQ   <= '0;
      readPrevQ <= 1'b0;
      intrN     <= 1'b1;
    end else begin
      stateQ    <= stateD;
      phaseQ    <= phaseWrap ? '0 : phaseQ + 1'b1;
      readPrevQ <= readNow;
      if (stateQ == ST_CONV && !holdActive && !bitEnd) bitCntQ <= bitCntQ + 1'b1;
      else                                             bitCntQ <= '0;
      if (holdActive)        intrN <= 1'b1;
      else if (strb.capture) intrN <= 1'b0;
      else if (readRise)     intrN <= 1'b1;
    end
  end

endmodule

// File: rtl/sar_adc_datapath.sv
module sar_adc_datapath
  import sar_adc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  sarStrobe_t       strb,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] resultQ,
  output logic             lastBit
);

  localparam logic [WIDTH-1:0] MSB_ONEHOT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] sarQ, ptrQ, keptBits, nextPtr;

  assign nextPtr  = ptrQ >> 1;
  assign keptBits = cmpHigh ? sarQ : (sarQ & ~ptrQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarQ    <= '0;
      ptrQ    <= '0;
      resultQ <= '0;
    end else begin
      if (strb.clrAll) begin
        sarQ <= '0;
        ptrQ <= '0;
      end else if (strb.loadMsb) begin
        sarQ <= MSB_ONEHOT;
        ptrQ <= MSB_ONEHOT;
      end else if (strb.decide) begin
        sarQ <= keptBits | nextPtr;
        ptrQ <= nextPtr;
      end
      if (strb.capture) resultQ <= sarQ;
    end
  end

  assign trialCode = sarQ;
  assign lastBit   = ptrQ[0];

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int BIT_CLKS    = 8,
  parameter int PHASE_DIV   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             rdN,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOe,
  output logic             intrN
);

  logic [2:0]       syncBus;
  logic             csSync, wrSync, rdSync;
  logic             holdActive, lastBit;
  logic [WIDTH-1:0] resultQ;
  sarStrobe_t       strb;

  sar_adc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({csN, wrN, rdN}),
    .syncOut (syncBus)
  );
  assign {csSync, wrSync, rdSync} = syncBus;

  sar_adc_ctrl #(.BIT_CLKS(BIT_CLKS), .PHASE_DIV(PHASE_DIV)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csSync     (csSync),
    .wrSync     (wrSync),
    .rdSync     (rdSync),
    .lastBit    (lastBit),
    .strb       (strb),
    .holdActive (holdActive),
    .intrN      (intrN)
  );

  sar_adc_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpHigh   (cmpHigh),
    .trialCode (trialCode),
    .resultQ   (resultQ),
    .lastBit   (lastBit)
  );

  assign dataOe  = !csN && !rdN;
  assign dataOut = dataOe ? resultQ : '0;

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk
  import sar_adc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             holdActive,
  input sarStrobe_t       strb,
  input logic [WIDTH-1:0] trialCode,
  input logic [WIDTH-1:0] resultQ,
  input logic [WIDTH-1:0] dataOut,
  input logic             dataOe,
  input logic             intrN
);

  p_hold_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    holdActive |=> (trialCode == '0 && intrN));

  p_intr_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intrN) |-> $past(strb.capture));

  p_result_kept_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(resultQ));

  p_trial_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clrAll || strb.loadMsb || strb.decide) |=> $stable(trialCode));

  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);

endmodule

bind sar_adc_seq sar_adc_seq_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .holdActive (holdActive),
  .strb       (strb),
  .trialCode  (trialCode),
  .resultQ    (resultQ),
  .dataOut    (dataOut),
  .dataOe     (dataOe),
  .intrN      (intrN)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, wrTask = 1'b1, rdN = 1'b1;
  logic       frMode = 1'b0, frKick = 1'b0;
  logic [7:0] analog = 8'h00;
  logic       wrN, cmpHigh, dataOe, intrN;
  logic [7:0] trialCode, dataOut;
  int         total = 0, fails = 0;
  bit         finished = 1'b0;

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h55, 8'hAA, 8'h01, 8'hFE};

  always #2 clk = ~clk;

  assign wrN     = frMode ? (intrN & ~frKick) : wrTask;
  assign cmpHigh = (analog >= trialCode);

  sar_adc_seq u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .dataOut(dataOut), .dataOe(dataOe), .intrN(intrN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startPulse(input int holdClks);
    @(negedge clk);
    csN = 1'b0; wrTask = 1'b0;
    waitNeg(holdClks);
    wrTask = 1'b1; csN = 1'b1;
  endtask

  // counts negedges from the release edge
  task automatic waitDone(output int startDly, output int doneDly, output logic [7:0] secondTrial);
    startDly = -1; doneDly = -1; secondTrial = 8'h00;
    for (int n = 1; n <= 120; n++) begin
      @(negedge clk);
      if (startDly < 0 && trialCode != 8'h00) startDly = n;
      if (startDly > 0 && n == startDly + 8) secondTrial = trialCode;
      if (!intrN) begin
        doneDly = n;
        break;
      end
    end
  endtask

  task automatic doRead(output logic [7:0] val);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0;
    #1 val = dataOut;
    waitNeg(4);
    csN = 1'b1; rdN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int sd, dd;
    logic [7:0] st, rv;
    int falls;
    logic [7:0] expCode;
    logic prevIntr;

    waitNeg(3);
    check(intrN == 1'b1 && trialCode == 8'h00, "R1 state during reset", {intrN, trialCode}, 9'h100);
    rstN = 1'b1;
    waitNeg(2);
    check(intrN == 1'b1, "R1 intrN after reset", intrN, 1);
    check(trialCode == 8'h00, "R1 trialCode after reset", trialCode, 0);
    check(dataOe == 1'b0 && dataOut == 8'h00, "R1 bus idle after reset", {dataOe, dataOut}, 0);

    // table walk: one full conversion and read per level
    for (int i = 0; i < 8; i++) begin
      logic [7:0] expSecond;
      analog = VEC[i];
      startPulse(4);
      waitDone(sd, dd, st);
      expSecond = (VEC[i] >= 8'h80 ? 8'h80 : 8'h00) | 8'h40;
      check(sd >= 3 && sd <= 8, "R3 start delay", sd, 3);
      check(dd >= 66 && dd <= 73, "R5 conversion time", dd, 73);
      check(st == expSecond, "R4 second trial", st, expSecond);
      @(negedge clk);
      csN = 1'b0; rdN = 1'b0;
      #1;
      check(dataOe == 1'b1, "R6 enable during read", dataOe, 1);
      check(dataOut == VEC[i], "R4 converted code", dataOut, VEC[i]);
      check(intrN == 1'b0, "R5 flag low before read takes effect", intrN, 0);
      waitNeg(4);
      check(intrN == 1'b1, "R6 read start clears flag", intrN, 1);
      csN = 1'b1; rdN = 1'b1;
      #1;
      check(dataOe == 1'b0 && dataOut == 8'h00, "R6 bus released", {dataOe, dataOut}, 0);
    end

    // R2: long hold with a pending flag
    analog = 8'h33;
    startPulse(4);
    waitDone(sd, dd, st);
    check(intrN == 1'b0, "R2 flag pending before hold", intrN, 0);
    @(negedge clk);
    csN = 1'b0; wrTask = 1'b0;
    waitNeg(4);
    check(intrN == 1'b1, "R2 hold raises flag", intrN, 1);
    check(trialCode == 8'h00, "R2 hold clears trial", trialCode, 0);
    waitNeg(40);
    check(trialCode == 8'h00 && intrN == 1'b1, "R2 still held", {intrN, trialCode}, 9'h100);
    wrTask = 1'b1; csN = 1'b1;
    waitDone(sd, dd, st);
    check(dd >= 66 && dd <= 73, "R2 conversion after hold", dd, 73);
    doRead(rv);
    check(rv == 8'h33, "R2 code after hold", rv, 8'h33);

    // R7: abort mid-conversion
    analog = 8'h5A;
    startPulse(4);
    waitDone(sd, dd, st);
    doRead(rv);
    check(rv == 8'h5A, "R7 baseline code", rv, 8'h5A);
    analog = 8'hC3;
    startPulse(4);
    waitNeg(30);
    check(trialCode != 8'h00 && intrN == 1'b1, "R7 conversion in flight", trialCode, 8'hC0);
    @(negedge clk);
    csN = 1'b0; wrTask = 1'b0; rdN = 1'b0;
    #1;
    check(dataOut == 8'h5A, "R7 latch kept on abort", dataOut, 8'h5A);
    waitNeg(60);
    check(dataOut == 8'h5A && intrN == 1'b1, "R7 no update after abort", dataOut, 8'h5A);
    rdN = 1'b1;
    waitNeg(1);
    wrTask = 1'b1; csN = 1'b1;
    waitDone(sd, dd, st);
    check(dd >= 66 && dd <= 73, "R7 restarted conversion completes", dd, 73);
    doRead(rv);
    check(rv == 8'hC3, "R7 new code after restart", rv, 8'hC3);

    // R8: free-running loop
    analog  = 8'h9C;
    expCode = 8'h9C;
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; frMode = 1'b1;
    waitNeg(100);
    check(intrN == 1'b1 && trialCode == 8'hC3, "R8 idle without kick", trialCode, 8'hC3);
    frKick = 1'b1;
    waitNeg(4);
    frKick = 1'b0;
    falls = 0;
    prevIntr = intrN;
    for (int n = 0; n < 600 && falls < 4; n++) begin
      @(negedge clk);
      if (!intrN && prevIntr) begin
        falls++;
        check(dataOe == 1'b1 && dataOut == expCode, "R8 free-running code", dataOut, expCode);
        if (falls == 2) begin
          analog  = 8'h21;
          expCode = 8'h21;
        end
        @(negedge clk);
        check(intrN == 1'b0, "R8 held read does not clear flag", intrN, 0);
      end
      prevIntr = intrN;
    end
    check(falls == 4, "R8 repeated conversions", falls, 4);
    frMode = 1'b0; wrTask = 1'b1; csN = 1'b1; rdN = 1'b1;
    waitNeg(4);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule